// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This unit sits behind the receive shift register of an I2C slave and decides whether the device is being called. It takes the first byte that arrives after a START condition and compares the upper seven bits against three programmable own addresses and against the general call address. For each own address that agrees, it sets a separate match flag. It also sets an addressed-as-slave flag and a general-call flag, latches the direction bit, and raises an interrupt request.

A format input turns address comparison off. In that mode every first byte raises the interrupt and no match flag is touched. The interface enable and a self-clearing soft reset both force the status back to idle. While the interface is disabled, the local data register ignores writes.

The status bit for a pending interrupt is active-low. Software acknowledges an interrupt by writing it back to 1 through `irq_clr`.

Top module: `i2c_saddr_unit`

## Requirements
- R1: While `enable` is 0, the status sits at its idle values one clock later: `pend_n`=1, `irq`=0, `match_flags`=0, `gcall_flag`=0, `aas_flag`=0, `trx_flag`=0 and `bus_busy`=0. START, STOP and address strobes have no effect while disabled.
- R2: `data_q` takes `data_in` when `data_we` is high and `enable` is 1. When `enable` is 0 the write is dropped and `data_q` keeps its value.
- R3: In addressing format (`fmt_free`=0), bit i of `match_flags` is set when `addr_byte[7:1]` equals own address i. Own address i sits in `own_addr[7*i+6:7*i]`. Every equal address sets its own flag at once. Any match also sets `aas_flag` and clears `pend_n`, so a single interrupt is raised.
- R4: An address byte of 8'h00 is a general call: it sets `gcall_flag` and `aas_flag` and clears `pend_n`. The byte 8'h01 is not a general call.
- R5: With `fmt_free`=1, every first byte clears `pend_n` and leaves `match_flags`, `gcall_flag` and `aas_flag` at 0.
- R6: Only the first strobed byte after a START is evaluated. Later bytes before the next START change no flag and no interrupt state.
- R7: On an accepted address, `trx_flag` takes `addr_byte[0]` (1 means transmit).
- R8: A START or a STOP clears `match_flags`, `gcall_flag`, `aas_flag` and `trx_flag`, but `pend_n` stays 0. `irq_clr` sets `pend_n` back to 1. A new accepted address in the same cycle as `irq_clr` wins. `irq` is always the inverse of `pend_n`.
- R9: A pulse on `srst_req` while enabled forces the idle status of R1 on the next clock. `srst_busy` then reads 1 for exactly 2 cycles and clears itself. A request while disabled is ignored.
- R10: `bus_busy` becomes 1 on the clock after a START and 0 on the clock after a STOP.
- R11: In addressing format, a first byte that matches no own address and is not a general call changes no flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Interface enable |
| fmt_free | input | 1 | 1 = free format, 0 = addressing format |
| own_addr | input | 21 | Three 7-bit own addresses, address i at bits 7i+6:7i |
| start_det | input | 1 | One-cycle START indication |
| stop_det | input | 1 | One-cycle STOP indication |
| addr_valid | input | 1 | Received byte strobe |
| addr_byte | input | 8 | Received byte: address in bits 7:1, R/W in bit 0 |
| irq_clr | input | 1 | Write of 1 to the pending bit |
| srst_req | input | 1 | Write of 1 to the soft reset bit |
| data_we | input | 1 | Data register write strobe |
| data_in | input | 8 | Data register write value |
| match_flags | output | 3 | Per own-address match flags |
| gcall_flag | output | 1 | General call detected |
| aas_flag | output | 1 | Addressed as slave |
| trx_flag | output | 1 | Direction from the address byte |
| pend_n | output | 1 | 0 = interrupt pending |
| irq | output | 1 | Interrupt request, active high |
| bus_busy | output | 1 | Bus busy between START and STOP |
| srst_busy | output | 1 | Soft reset bit readback, self-clearing |
| data_q | output | 8 | Data register |

## Verification
The assertions assume that `start_det`, `stop_det` and `addr_valid` are single-cycle strobes. They also assume that a new START is only ever followed by its address byte on a later clock, never in the same cycle. The bench drives every strobe for exactly one cycle on the falling edge and separates a START from its byte by a full cycle. It changes `own_addr` and `fmt_free` only while no strobe is active. Stimulus that breaks these assumptions, such as a STOP together with an address strobe, is only sent in situations where the priority order is part of a requirement.

// File: rtl/i2c_saddr_pkg.sv
package i2c_saddr_pkg;
  localparam int ADDR_W   = 7;
  localparam int BYTE_W   = 8;
  localparam logic [BYTE_W-1:0] GCALL_BYTE = 8'h00;

  typedef struct packed {
    logic       gcall;
    logic       aas;
    logic       trx;
    logic       pend_n;
    logic       busy;
  } stat_t;

  localparam stat_t STAT_IDLE = '{gcall: 1'b0, aas: 1'b0, trx: 1'b0,
                                  pend_n: 1'b1, busy: 1'b0};

  function automatic logic [ADDR_W-1:0] call_addr(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return b == GCALL_BYTE;
  endfunction
endpackage

// File: rtl/i2c_saddr_cmp.sv
module i2c_saddr_cmp
  import i2c_saddr_pkg::*;
#(
  parameter int N_OWN = 3
) (
  input  logic [BYTE_W-1:0]       byte_in,
  input  logic [N_OWN*ADDR_W-1:0] own_addr,
  output logic [N_OWN-1:0]        own_hit,
  output logic                    gc_hit,
  output logic                    any_hit
);
  logic [ADDR_W-1:0] caddr;
  assign caddr = call_addr(byte_in);

  genvar gi;
  generate
    for (gi = 0; gi < N_OWN; gi++) begin : g_cmp
      assign own_hit[gi] = (caddr == own_addr[gi*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign gc_hit  = is_gcall(byte_in);
  assign any_hit = (|own_hit) | gc_hit;
endmodule

// File: rtl/i2c_saddr_srst.sv
module i2c_saddr_srst #(
  parameter int SRST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic srst_req,
  output logic srst_busy
);
  localparam int CW = $clog2(SRST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SRST_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_busy <= 1'b0;
      cnt       <= '0;
    end else if (!enable) begin
      srst_busy <= 1'b0;
      cnt       <= '0;
    end else if (srst_busy) begin
      if (cnt == LAST) begin
        srst_busy <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (srst_req) begin
      srst_busy <= 1'b1;
      cnt       <= '0;
    end
  end

  // Independent watch of how long the bit stays high
  logic [CW:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (srst_busy) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  AST_SRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= (CW+1)'(SRST_CYC)); // R9
  AST_SRST_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !srst_busy); // R9
endmodule

// File: rtl/i2c_saddr_stat.sv
module i2c_saddr_stat
  import i2c_saddr_pkg::*;
#(
  parameter int N_OWN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_force,
  input  logic               fmt_free,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               addr_valid,
  input  logic               rw_bit,
  input  logic [N_OWN-1:0]   own_hit,
  input  logic               gc_hit,
  input  logic               any_hit,
  input  logic               irq_clr,
  output logic [N_OWN-1:0]   match_q,
  output stat_t              st_q
);
  logic armed;
  logic take;
  logic accept;

  assign take   = addr_valid & armed & ~start_det & ~stop_det;
  assign accept = take & ~fmt_free & any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= STAT_IDLE;
      match_q <= '0;
      armed   <= 1'b0;
    end else if (idle_force) begin
      st_q    <= STAT_IDLE;
      match_q <= '0;
      armed   <= 1'b0;
    end else begin
      if (irq_clr) st_q.pend_n <= 1'b1;
      if (stop_det) begin
        match_q  <= '0;
        st_q.gcall <= 1'b0;
        st_q.aas   <= 1'b0;
        st_q.trx   <= 1'b0;
        st_q.busy  <= 1'b0;
        armed      <= 1'b0;
      end else if (start_det) begin
        match_q  <= '0;
        st_q.gcall <= 1'b0;
        st_q.aas   <= 1'b0;
        st_q.trx   <= 1'b0;
        st_q.busy  <= 1'b1;
        armed      <= 1'b1;
      end else if (take) begin
        armed <= 1'b0;
        if (fmt_free) begin
          st_q.pend_n <= 1'b0;
        end else if (any_hit) begin
          match_q     <= own_hit;
          st_q.gcall  <= gc_hit;
          st_q.aas    <= 1'b1;
          st_q.trx    <= rw_bit;
          st_q.pend_n <= 1'b0;
        end
      end
    end
  end

  AST_IDLE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_force |=> (st_q.pend_n && match_q == '0 && !st_q.gcall && !st_q.aas
                    && !st_q.trx && !st_q.busy)); // R1
  AST_HIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !idle_force) |=> (!st_q.pend_n && st_q.aas)); // R3
  AST_FREE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fmt_free && !idle_force) |=> (!st_q.pend_n && match_q == '0 && !st_q.aas)); // R5
  AST_GC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.gcall) |-> $past(gc_hit)); // R4
  AST_LATE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !armed && !start_det && !stop_det && !idle_force && !irq_clr)
      |=> ($stable(st_q.pend_n) && $stable(match_q))); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det && !idle_force) |=> st_q.busy); // R10
endmodule

// File: rtl/i2c_saddr_unit.sv
module i2c_saddr_unit
  import i2c_saddr_pkg::*;
#(
  parameter int N_OWN    = 3,
  parameter int SRST_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    fmt_free,
  input  logic [N_OWN*ADDR_W-1:0] own_addr,
  input  logic                    start_det,
  input  logic                    stop_det,
  input  logic                    addr_valid,
  input  logic [BYTE_W-1:0]       addr_byte,
  input  logic                    irq_clr,
  input  logic                    srst_req,
  input  logic                    data_we,
  input  logic [BYTE_W-1:0]       data_in,
  output logic [N_OWN-1:0]        match_flags,
  output logic                    gcall_flag,
  output logic                    aas_flag,
  output logic                    trx_flag,
  output logic                    pend_n,
  output logic                    irq,
  output logic                    bus_busy,
  output logic                    srst_busy,
  output logic [BYTE_W-1:0]       data_q
);
  logic [N_OWN-1:0] own_hit;
  logic             gc_hit;
  logic             any_hit;
  logic             idle_force;
  stat_t            st;

  i2c_saddr_cmp #(.N_OWN(N_OWN)) u_cmp (
    .byte_in (addr_byte),
    .own_addr(own_addr),
    .own_hit (own_hit),
    .gc_hit  (gc_hit),
    .any_hit (any_hit)
  );

  i2c_saddr_srst #(.SRST_CYC(SRST_CYC)) u_srst (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .srst_req (srst_req),
    .srst_busy(srst_busy)
  );

  assign idle_force = ~enable | srst_busy | srst_req;

  i2c_saddr_stat #(.N_OWN(N_OWN)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_force(idle_force),
    .fmt_free  (fmt_free),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_valid(addr_valid),
    .rw_bit    (addr_byte[0]),
    .own_hit   (own_hit),
    .gc_hit    (gc_hit),
    .any_hit   (any_hit),
    .irq_clr   (irq_clr),
    .match_q   (match_flags),
    .st_q      (st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                data_q <= '0;
    else if (data_we && enable) data_q <= data_in;
  end

  assign gcall_flag = st.gcall;
  assign aas_flag   = st.aas;
  assign trx_flag   = st.trx;
  assign pend_n     = st.pend_n;
  assign irq        = ~st.pend_n;
  assign bus_busy   = st.busy;

  AST_DATA_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(data_q)); // R2
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_req && enable) |=> (pend_n && match_flags == '0 && !aas_flag)); // R9
endmodule

// File: tb/i2c_saddr_unit_bench.sv
module i2c_saddr_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enable, fmt_free, start_det, stop_det, addr_valid, irq_clr, srst_req, data_we;
  logic [20:0] own_addr;
  logic [7:0]  addr_byte, data_in;
  logic [2:0]  match_flags;
  logic gcall_flag, aas_flag, trx_flag, pend_n, irq, bus_busy, srst_busy;
  logic [7:0] data_q;

  i2c_saddr_unit u_i2c_saddr_unit (.*);

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int m_match, m_gc, m_aas, m_trx, m_pend, m_busy, m_sbusy, m_scnt, m_data, m_armed;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_match = 0; m_gc = 0; m_aas = 0; m_trx = 0; m_pend = 1; m_busy = 0;
      m_sbusy = 0; m_scnt = 0; m_data = 0; m_armed = 0;
    end else begin
      int forced, hits, ca;
      forced = (!enable || m_sbusy != 0 || srst_req) ? 1 : 0;
      if (!enable) begin m_sbusy = 0; m_scnt = 0; end
      else if (m_sbusy != 0) begin
        m_scnt++;
        if (m_scnt == 2) begin m_sbusy = 0; m_scnt = 0; end
      end else if (srst_req) begin m_sbusy = 1; m_scnt = 0; end
      if (enable && data_we) m_data = data_in;
      if (forced != 0) begin
        m_match = 0; m_gc = 0; m_aas = 0; m_trx = 0; m_pend = 1; m_busy = 0; m_armed = 0;
      end else begin
        if (irq_clr) m_pend = 1;
        if (stop_det) begin
          m_match = 0; m_gc = 0; m_aas = 0; m_trx = 0; m_busy = 0; m_armed = 0;
        end else if (start_det) begin
          m_match = 0; m_gc = 0; m_aas = 0; m_trx = 0; m_busy = 1; m_armed = 1;
        end else if (addr_valid && m_armed != 0) begin
          m_armed = 0;
          ca = addr_byte / 2;
          hits = 0;
          for (int i = 0; i < 3; i++)
            if (ca == int'((own_addr >> (7*i)) & 21'h7f)) hits += (1 << i);
          if (fmt_free) m_pend = 0;
          else if (hits != 0 || addr_byte == 8'h00) begin
            m_match = hits; m_gc = (addr_byte == 8'h00) ? 1 : 0;
            m_aas = 1; m_trx = addr_byte % 2; m_pend = 0;
          end
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n !== 1'bx && !done) begin
    chk("match_flags", int'(match_flags), m_match);
    chk("gcall_flag", int'(gcall_flag), m_gc);
    chk("aas_flag", int'(aas_flag), m_aas);
    chk("trx_flag", int'(trx_flag), m_trx);
    chk("pend_n", int'(pend_n), m_pend);
    chk("irq", int'(irq), 1 - m_pend);
    chk("bus_busy", int'(bus_busy), m_busy);
    chk("srst_busy", int'(srst_busy), m_sbusy);
    chk("data_q", int'(data_q), m_data);
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic clear_strobes();
    start_det = 0; stop_det = 0; addr_valid = 0; irq_clr = 0; srst_req = 0; data_we = 0;
  endtask
  task automatic do_start(); start_det = 1; cyc(); clear_strobes(); endtask
  task automatic do_stop();  stop_det = 1;  cyc(); clear_strobes(); endtask
  task automatic do_byte(logic [7:0] b); addr_valid = 1; addr_byte = b; cyc(); clear_strobes(); endtask
  task automatic do_addr(logic [7:0] b); do_start(); do_byte(b); cyc(); endtask
  task automatic do_clr(); irq_clr = 1; cyc(); clear_strobes(); endtask
  task automatic do_write(logic [7:0] v); data_we = 1; data_in = v; cyc(); clear_strobes(); endtask

  initial begin
    #1ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; fmt_free = 0; addr_byte = 0; data_in = 0;
    own_addr = {7'h56, 7'h34, 7'h12};
    clear_strobes();
    cyc(3);
    rst_n = 1; cyc(2);
    cur_req = "R1"; do_addr(8'h24); do_start();           // disabled: ignored
    cur_req = "R2"; do_write(8'hA5); cyc();
    enable = 1; cyc();
    cur_req = "R2"; do_write(8'h3C); cyc();
    cur_req = "R3"; do_addr(8'h24); do_clr(); do_addr(8'hAC); do_clr();
    cur_req = "R7"; do_addr(8'h69); do_clr();
    cur_req = "R11"; do_addr(8'h98); do_addr(8'h26);
    cur_req = "R3"; own_addr = {7'h12, 7'h34, 7'h12}; cyc(); do_addr(8'h25); do_clr();
    own_addr = {7'h56, 7'h34, 7'h12}; cyc();
    cur_req = "R4"; do_addr(8'h00); do_clr(); do_addr(8'h01);
    cur_req = "R6"; do_start(); do_byte(8'h77); do_byte(8'h24); cyc();
    do_start(); do_byte(8'h24); do_clr(); do_byte(8'h00); cyc();
    cur_req = "R8"; do_addr(8'h68); do_stop(); cyc(); do_start(); cyc(); do_clr();
    cur_req = "R8"; do_start(); irq_clr = 1; do_byte(8'h24); cyc();
    cur_req = "R10"; do_stop(); cyc(); do_start(); cyc(); do_stop();
    cur_req = "R5"; fmt_free = 1; cyc(); do_addr(8'h98); do_clr(); do_addr(8'h24);
    fmt_free = 0; cyc(); do_clr();
    cur_req = "R9"; do_addr(8'h24); srst_req = 1; cyc(); clear_strobes(); cyc(4);
    do_addr(8'h00); srst_req = 1; cyc(); clear_strobes(); do_start(); do_byte(8'h24); cyc(3);
    cur_req = "R1"; do_addr(8'h24); enable = 0; cyc(2);
    cur_req = "R9"; srst_req = 1; cyc(); clear_strobes(); cyc(2);
    cur_req = "R2"; do_write(8'h11); enable = 1; cyc(); do_write(8'h22); cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule